// File: doc/BRIEF.md
# Circular Sampling-Ring Readout Sequencer

This block controls the readout of a ring of analog sampling cells. While armed, it advances a write-position counter once per clock. The counter goes round the ring without end and tells the analog array which cell is being written. A trigger stops sampling and freezes that counter. The frozen value is the reference point for the readout.

After the freeze, the block walks a window of cells. The window begins a programmable number of cells after the frozen position and spans a programmable number of cells. Cell addresses are taken modulo the ring size, so a window that runs past the top cell continues at cell 0. One address goes out to the external converter interface per clock, and each sample returns a fixed number of clocks later. A loadable table holds a signed offset for every cell. The block subtracts that offset from each returned sample and presents the result as a stream with valid and last flags that line up with the returned data.

The offset table can be written only while the block is idle. After the last corrected sample has been emitted, the block returns to idle and waits to be armed again.

Top module: `ring_readout_seq`

## Requirements
- R1: While sampling runs (`ring_run`=1) and no trigger is present, `wr_cell` advances by one each clock. It goes from 1023 back to 0 without stopping.
- R2: `arm` is accepted only in the idle state. If it is sampled high at a clock edge while idle, `ring_run` is 1 in the next cycle.
- R3: A trigger sampled while running drops `ring_run` and leaves `wr_cell` at the value it had in the trigger cycle. That value is the stop position. `wr_cell` then holds until the next arm. A trigger in any other state has no effect.
- R4: The k-th request (k = 0 .. W-1) carries address (stop + `roi_start` + k) mod 1024. Requests are issued on consecutive cycles, and the first is issued two cycles after the trigger cycle.
- R5: A window that passes cell 1023 continues at cell 0.
- R6: The sample for a request returns on `adc_data` exactly 2 cycles after that request. In that same cycle `out_valid` is 1 and `out_data` is the sample, read as unsigned, minus the signed 16-bit offset of that cell, given as a 17-bit two's-complement value.
- R7: `out_last` is 1 only together with the final sample of a window.
- R8: A width of 0 produces no request and no output. The block returns to idle after one cycle and accepts `arm` again.
- R9: A table write (`tbl_we`=1 at a clock edge) stores `tbl_wdata` for cell `tbl_addr` only while the block is idle. Writes in any other state are ignored.
- R10: Once the last sample has been emitted the block is idle. An `arm` seen during readout is ignored, so sampling stays off after that readout.
- R11: After reset, `wr_cell` is 0 and `ring_run`, `adc_req` and `out_valid` are 0.
- R12: A requested width above 1024 is treated as 1024, so each cell is read exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the readout |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start sampling (accepted when idle) |
| trigger | input | 1 | Stop sampling and freeze the position |
| roi_start | input | 10 | Window start, in cells after the stop position |
| roi_width | input | 11 | Window length in cells (0 to 2047, clamped to 1024) |
| tbl_we | input | 1 | Offset table write strobe |
| tbl_addr | input | 10 | Offset table cell index |
| tbl_wdata | input | 16 | Signed offset value |
| wr_cell | output | 10 | Current or frozen write position |
| ring_run | output | 1 | Sampling active |
| adc_req | output | 1 | Conversion request valid |
| adc_addr | output | 10 | Cell to convert |
| adc_data | input | 14 | Returned sample, 2 cycles after its request |
| out_valid | output | 1 | Corrected sample valid |
| out_last | output | 1 | Final sample of the window |
| out_data | output | 17 | Sample minus cell offset, signed |

## Verification
Windows are read at several points on the ring. A window well inside the ring checks the basic start offset. A window that straddles cell 1023 tells modulo addressing apart from plain addition. A start offset large enough to wrap the base itself checks the modulo on the base. An oversized width covers the whole ring and separates clamping from overrun. The offset table holds a distinct value for every cell plus both signed extremes, so a wrong cell index or a wrong sign extension shows up directly in the corrected data. Triggers, arms and table writes are also applied in states where they must be ignored, and the state each of them could have changed is then read back through the outputs.

// File: rtl/ringseq_pkg.sv
package ringseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_STOP = 2'd2,
    SEQ_READ = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import ringseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       trigger,
  input  logic       win_zero,
  input  logic       stream_done,
  output seq_state_t st,
  output logic       ring_run,
  output logic       advance,
  output logic       win_load,
  output logic       in_read,
  output logic       tbl_open
);
  seq_state_t st_n;

  always_comb begin
    st_n = st;
    unique case (st)
      SEQ_IDLE: if (arm)         st_n = SEQ_RUN;
      SEQ_RUN:  if (trigger)     st_n = SEQ_STOP;
      SEQ_STOP: st_n = win_zero ? SEQ_IDLE : SEQ_READ;
      SEQ_READ: if (stream_done) st_n = SEQ_IDLE;
      default:  st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SEQ_IDLE;
    else        st <= st_n;
  end

  assign ring_run = (st == SEQ_RUN);
  assign advance  = ring_run && !trigger;
  assign win_load = (st == SEQ_STOP);
  assign in_read  = (st == SEQ_READ);
  assign tbl_open = (st == SEQ_IDLE);
endmodule

// File: rtl/rs_pos_track.sv
module rs_pos_track #(
  parameter int CELLS = 1024,
  localparam int AW = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [AW-1:0] pos
);
  localparam logic [AW-1:0] TOP_CELL = AW'(CELLS - 1);

  function automatic logic [AW-1:0] step_cell(input logic [AW-1:0] c);
    return (c == TOP_CELL) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (advance) pos <= step_cell(pos);
  end
endmodule

// File: rtl/rs_roi_gen.sv
module rs_roi_gen #(
  parameter int CELLS = 1024,
  localparam int AW = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_read,
  input  logic [AW-1:0] stop_pos,
  input  logic [AW-1:0] start,
  input  logic [AW:0]   width_req,
  output logic          win_zero,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic          req_last
);
  localparam logic [AW:0] RING_N = (AW+1)'(CELLS);

  function automatic logic [AW-1:0] cell_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= RING_N) s = s - RING_N;
    return s[AW-1:0];
  endfunction

  logic [AW-1:0] base_q;
  logic [AW:0]   total_q, issued_q, width_eff;

  assign width_eff = (width_req > RING_N) ? RING_N : width_req;
  assign win_zero  = (width_eff == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      total_q  <= '0;
      issued_q <= '0;
    end else if (load) begin
      base_q   <= cell_add(stop_pos, start);
      total_q  <= width_eff;
      issued_q <= '0;
    end else if (req) begin
      issued_q <= issued_q + 1'b1;
    end
  end

  assign req      = in_read && (issued_q < total_q);
  assign req_addr = cell_add(base_q, issued_q[AW-1:0]);
  assign req_last = req && (issued_q == total_q - 1'b1);
endmodule

// File: rtl/rs_ofs_table.sv
module rs_ofs_table #(
  parameter int CELLS = 1024,
  parameter int OW    = 16,
  localparam int AW = $clog2(CELLS)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [OW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [OW-1:0] rdata
);
  logic signed [OW-1:0] mem [CELLS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rs_corr_pipe.sv
module rs_corr_pipe #(
  parameter int LAT = 2,
  parameter int SW  = 14,
  parameter int OW  = 16,
  parameter int RW  = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 req_last,
  input  logic signed [OW-1:0] ofs_now,
  input  logic [SW-1:0]        adc_data,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [RW-1:0] out_data
);
  function automatic logic signed [RW-1:0] corrected(input logic [SW-1:0] s,
                                                     input logic [OW-1:0] o);
    logic [RW-1:0] se, oe;
    se = {{(RW-SW){1'b0}}, s};
    oe = {{(RW-OW){o[OW-1]}}, o};
    return $signed(se - oe);
  endfunction

  logic [LAT-1:0] v_q, l_q;
  logic signed [OW-1:0] ofs_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      l_q <= '0;
    end else begin
      v_q[0] <= req;
      l_q[0] <= req_last;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        l_q[i] <= l_q[i-1];
      end
    end
  end

  generate
    if (LAT == 1) begin : g_direct
      assign ofs_out = ofs_now;
    end else begin : g_delay
      logic signed [OW-1:0] o_q [LAT-1];
      always_ff @(posedge clk) begin
        o_q[0] <= ofs_now;
        for (int i = 1; i < LAT - 1; i++) o_q[i] <= o_q[i-1];
      end
      assign ofs_out = o_q[LAT-2];
    end
  endgenerate

  assign out_valid = v_q[LAT-1];
  assign out_last  = v_q[LAT-1] && l_q[LAT-1];
  assign out_data  = corrected(adc_data, ofs_out);
endmodule

// File: rtl/ring_readout_seq.sv
module ring_readout_seq
  import ringseq_pkg::*;
#(
  parameter int CELLS    = 1024,
  parameter int SAMPLE_W = 14,
  parameter int OFS_W    = 16,
  parameter int ADC_LAT  = 2,
  localparam int AW = $clog2(CELLS),
  localparam int RW = ((SAMPLE_W + 1 > OFS_W) ? SAMPLE_W + 1 : OFS_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 trigger,
  input  logic [AW-1:0]        roi_start,
  input  logic [AW:0]          roi_width,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic signed [OFS_W-1:0] tbl_wdata,
  output logic [AW-1:0]        wr_cell,
  output logic                 ring_run,
  output logic                 adc_req,
  output logic [AW-1:0]        adc_addr,
  input  logic [SAMPLE_W-1:0]  adc_data,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [RW-1:0] out_data
);
  seq_state_t seq_st;
  logic advance, win_load, in_read, tbl_open, win_zero, req_last, stream_done;
  logic signed [OFS_W-1:0] ofs_now;

  assign stream_done = out_valid && out_last;

  rs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trigger(trigger),
    .win_zero(win_zero), .stream_done(stream_done), .st(seq_st),
    .ring_run(ring_run), .advance(advance), .win_load(win_load),
    .in_read(in_read), .tbl_open(tbl_open)
  );

  rs_pos_track #(.CELLS(CELLS)) u_pos (
    .clk(clk), .rst_n(rst_n), .advance(advance), .pos(wr_cell)
  );

  rs_roi_gen #(.CELLS(CELLS)) u_roi (
    .clk(clk), .rst_n(rst_n), .load(win_load), .in_read(in_read),
    .stop_pos(wr_cell), .start(roi_start), .width_req(roi_width),
    .win_zero(win_zero), .req(adc_req), .req_addr(adc_addr),
    .req_last(req_last)
  );

  rs_ofs_table #(.CELLS(CELLS), .OW(OFS_W)) u_tbl (
    .clk(clk), .we(tbl_we && tbl_open), .waddr(tbl_addr),
    .wdata(tbl_wdata), .raddr(adc_addr), .rdata(ofs_now)
  );

  rs_corr_pipe #(.LAT(ADC_LAT), .SW(SAMPLE_W), .OW(OFS_W), .RW(RW)) u_corr (
    .clk(clk), .rst_n(rst_n), .req(adc_req), .req_last(req_last),
    .ofs_now(ofs_now), .adc_data(adc_data), .out_valid(out_valid),
    .out_last(out_last), .out_data(out_data)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker
  import ringseq_pkg::*;
#(
  parameter int CELLS = 1024,
  parameter int LAT   = 2,
  localparam int AW = $clog2(CELLS)
) (
  input logic          clk,
  input logic          rst_n,
  input seq_state_t    st,
  input logic          ring_run,
  input logic          trigger,
  input logic [AW-1:0] wr_cell,
  input logic          adc_req,
  input logic [AW-1:0] adc_addr,
  input logic          out_valid,
  input logic          out_last
);
  localparam logic [AW-1:0] TOP_CELL = AW'(CELLS - 1);
  int pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 0;
    else        pend <= pend + int'(adc_req) - int'(out_valid);
  end

  a_r1_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_run && !trigger) |=>
      wr_cell == (($past(wr_cell) == TOP_CELL) ? '0 : $past(wr_cell) + 1'b1));

  a_r3_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_run || trigger) |=> $stable(wr_cell));

  a_r3_stop_run: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_run && trigger) |=> !ring_run);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && $past(adc_req)) |->
      adc_addr == (($past(adc_addr) == TOP_CELL) ? '0 : $past(adc_addr) + 1'b1));

  a_r4_req_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> !ring_run);

  a_r6_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend != 0);

  a_r6_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= LAT);

  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> st == SEQ_IDLE);
endmodule

bind ring_readout_seq rs_checker #(.CELLS(CELLS), .LAT(ADC_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(seq_st), .ring_run(ring_run),
  .trigger(trigger), .wr_cell(wr_cell), .adc_req(adc_req),
  .adc_addr(adc_addr), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/sim_ring_readout_seq.sv
module sim_ring_readout_seq;
  localparam int CELLS = 1024, SW = 14, OW = 16, LAT = 2, AW = 10, RW = 17;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, arm = 1'b0, trigger = 1'b0, tbl_we = 1'b0;
  logic [AW-1:0] roi_start = '0, tbl_addr = '0;
  logic [AW:0] roi_width = '0;
  logic signed [OW-1:0] tbl_wdata = '0;
  logic [AW-1:0] wr_cell, adc_addr;
  logic ring_run, adc_req, out_valid, out_last;
  logic [SW-1:0] adc_data;
  logic signed [RW-1:0] out_data;

  ring_readout_seq #(.CELLS(CELLS), .SAMPLE_W(SW), .OFS_W(OW), .ADC_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trigger(trigger),
    .roi_start(roi_start), .roi_width(roi_width), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .wr_cell(wr_cell),
    .ring_run(ring_run), .adc_req(adc_req), .adc_addr(adc_addr),
    .adc_data(adc_data), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data)
  );

  int total = 0, bad = 0, cyc = 0;
  int ofs_m [CELLS];
  int req_cyc [CELLS + 8];
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int samp(input int a);
    return (a * 37 + 911) % 16384;
  endfunction

  // converter model: address captured at the request edge, data two cycles on
  logic [AW-1:0] a1 = '0, a2 = '0;
  always @(posedge clk) begin
    a1 <= adc_addr;
    a2 <= a1;
  end
  assign adc_data = SW'(samp(int'(a2)));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_arm();
    @(posedge clk); #1 arm = 1'b1;
    @(posedge clk); #1 arm = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(wr_cell == 0, "R11 wr_cell", int'(wr_cell), 0);
    chk(!ring_run && !adc_req && !out_valid, "R11 flags",
        int'({ring_run, adc_req, out_valid}), 0);
  endtask

  task automatic t_load();
    for (int i = 0; i < CELLS; i++) begin
      int v;
      v = (i == 5) ? -32768 : (i == 6) ? 32767 : ((i * 113) % 4001) - 2000;
      @(posedge clk); #1 tbl_we = 1'b1; tbl_addr = AW'(i); tbl_wdata = OW'(v);
      ofs_m[i] = v;
    end
    @(posedge clk); #1 tbl_we = 1'b0;
  endtask

  task automatic t_idle_trigger();
    int p;
    @(negedge clk); p = int'(wr_cell);
    @(posedge clk); #1 trigger = 1'b1;
    @(posedge clk); #1 trigger = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!ring_run && !adc_req && int'(wr_cell) == p, "R3 idle trigger ignored",
          int'(wr_cell), p);
    end
  endtask

  // mode bit0: arm+trigger poked mid-readout; bit1: table writes outside idle
  task automatic t_window(input int min_run, input int target, input int start,
                          input int width, input int mode, input int lock_cell);
    int weff, prev, stop, tcyc, n_req, n_out;
    bit wrapped;
    weff = (width > CELLS) ? CELLS : width;
    roi_start = AW'(start);
    roi_width = (AW+1)'(width);
    pulse_arm();
    @(negedge clk);
    chk(ring_run, "R2 arm starts sampling", int'(ring_run), 1);
    prev = int'(wr_cell);
    wrapped = 1'b0;
    if (mode[1]) begin
      tbl_we = 1'b1; tbl_addr = AW'(lock_cell); tbl_wdata = 16'sd1234;
    end
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      tbl_we = 1'b0;
      chk(int'(wr_cell) == (prev + 1) % CELLS, "R1 step", int'(wr_cell), (prev + 1) % CELLS);
      if (prev == CELLS - 1) wrapped = 1'b1;
      prev = int'(wr_cell);
      if (k >= min_run && prev == (target + CELLS - 1) % CELLS) break;
    end
    if (min_run > CELLS) chk(wrapped, "R1 wrap 1023->0", int'(wrapped), 1);
    @(posedge clk); #1 trigger = 1'b1; tcyc = cyc;
    @(negedge clk); stop = int'(wr_cell);
    chk(stop == target, "R3 stop position", stop, target);
    @(posedge clk); #1 trigger = 1'b0;
    n_req = 0; n_out = 0;
    for (int k = 0; k < weff + 12; k++) begin
      @(negedge clk);
      if (mode[0] && k == weff / 2 + 1) begin arm = 1'b0; trigger = 1'b0; end
      if (mode[1] && k == 1) tbl_we = 1'b0;
      chk(int'(wr_cell) == stop && !ring_run, "R3 frozen", int'(wr_cell), stop);
      if (adc_req) begin
        int ea;
        ea = (stop + start + n_req) % CELLS;
        if (n_req == 0) chk(cyc == tcyc + 2, "R4 first request cycle", cyc, tcyc + 2);
        chk(int'(adc_addr) == ea, "R4 R5 address", int'(adc_addr), ea);
        if (n_req < CELLS + 8) req_cyc[n_req] = cyc;
        n_req++;
      end
      if (out_valid) begin
        int ea, ev;
        ea = (stop + start + n_out) % CELLS;
        ev = samp(ea) - ofs_m[ea];
        chk(int'(out_data) == ev, "R6 R9 corrected data", int'(out_data), ev);
        if (n_out < n_req)
          chk(cyc == req_cyc[n_out] + 2, "R6 latency", cyc, req_cyc[n_out] + 2);
        chk(out_last == (n_out == weff - 1), "R7 last flag", int'(out_last),
            int'(n_out == weff - 1));
        n_out++;
      end
      if (mode[0] && k == weff / 2) begin arm = 1'b1; trigger = 1'b1; end
      if (mode[1] && k == 0) begin
        tbl_we = 1'b1; tbl_addr = AW'(lock_cell + 2); tbl_wdata = -16'sd999;
      end
    end
    chk(n_req == weff, "R4 R12 request count", n_req, weff);
    chk(n_out == weff, "R7 R12 output count", n_out, weff);
    chk(!ring_run && !out_valid, "R10 idle after last", int'(ring_run), 0);
  endtask

  task automatic t_zero_width();
    roi_width = '0;
    roi_start = 10'd7;
    pulse_arm();
    repeat (5) @(negedge clk);
    @(posedge clk); #1 trigger = 1'b1;
    @(posedge clk); #1 trigger = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!adc_req && !out_valid && !ring_run, "R8 zero width silent",
          int'({adc_req, out_valid, ring_run}), 0);
    end
    pulse_arm();
    @(negedge clk);
    chk(ring_run, "R8 re-arm after zero width", int'(ring_run), 1);
    @(posedge clk); #1 trigger = 1'b1;
    @(posedge clk); #1 trigger = 1'b0;
    repeat (4) @(negedge clk);
    chk(!ring_run && !adc_req, "R8 second zero window", int'(ring_run), 0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_idle_trigger();
    t_window(1100, 3, 10, 20, 0, 0);
    t_window(0, 1015, 3, 13, 0, 0);
    t_window(0, 100, 1000, 40, 1, 0);
    t_window(0, 700, 900, 1500, 0, 0);
    t_zero_width();
    t_window(0, 200, 0, 8, 2, 203);
    t_window(0, 1023, 1, 2, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule